// File: doc/BRIEF.md
# Reciprocal Square-Root Estimator

This block produces a seven-bit-accurate approximation of 1/sqrt(x) for a floating-point operand in IEEE-754 half, single or double precision. A two-bit format code picks the precision. The operand is presented right-aligned on a 64-bit bus, and the result comes back right-aligned in the same way.

Inside the block, a classifier sorts the operand into one of several classes: zero, subnormal, infinity, quiet NaN, signalling NaN or normal. A subnormal operand goes through a leading-zero normaliser first. A 128-entry table of seven-bit mantissa estimates is addressed by the exponent parity and the six leading fraction bits. The result exponent is computed from the biased input exponent.

An operand is accepted with a valid/ready handshake. The result, together with an invalid flag and a divide-by-zero flag, is held in an output register until the consumer takes it.

Top module: `rsqrt_est`

## Requirements
- R1: The format code selects half (0: 5 exponent bits, 10 fraction bits), single (1: 8/23) or double (2: 11/52). The result is right-aligned with zeros above the format width, and operand bits above the format width are ignored. Code 3 returns 0x7FF8000000000000 with the invalid flag set.
- R2: A negative nonzero operand that is not a NaN (negative normal, negative subnormal, negative infinity) returns the canonical quiet NaN and raises the invalid flag. The canonical quiet NaN has sign 0, an all-ones exponent, and only the top fraction bit set.
- R3: A NaN with fraction MSB 0 (signalling) returns the canonical quiet NaN with invalid set. A NaN with fraction MSB 1 (quiet) returns the canonical quiet NaN with no flag. The sign of a NaN operand has no effect.
- R4: +0 returns +infinity and -0 returns -infinity. Both raise the divide-by-zero flag and never the invalid flag.
- R5: +infinity returns +0 with no flag raised.
- R6: For a positive normal operand with biased exponent e and fraction f, the table index is {e[0], six fraction MSBs}. Indices 0..63 hold 52 falling to 0 and indices 64..127 hold 127 falling to 53. The result has sign 0, exponent floor((3*bias - 1 - e)/2), the table value in the top seven fraction bits, and zeros in every lower fraction bit.
- R7: For a positive subnormal operand, the fraction is shifted left until its MSB is 1, and each shift decrements a working exponent that starts at 0. The fraction is then shifted once more to drop the leading one. The index and the exponent rule of R6 are applied to the results.
- R8: in_ready is high when out_valid is low or out_ready is high. An accepted operand appears on the outputs one clock later with out_valid high. While out_ready is low, out_valid and the result stay unchanged.
- R9: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Block can take an operand |
| in_fmt | input | 2 | Format code (0 half, 1 single, 2 double) |
| in_op | input | 64 | Right-aligned operand |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Right-aligned estimate |
| out_invalid | output | 1 | Invalid-operation flag |
| out_divzero | output | 1 | Divide-by-zero flag |

## Verification
The hardest path to reach from the ports is the subnormal normaliser. Uniformly random bit patterns almost never produce a zero exponent, and when they do, the shift distance is usually small. The stimulus therefore includes a batch of positive subnormals per format in which the exponent is forced to zero and the fraction is cut to a random length. This puts the leading one at every position, including the lowest fraction bit, and checks both exponent parities of the shifted result. Directed operands cover the first and last entry of each table half, and a stall sequence holds the consumer off while a second operand is waiting.

// File: rtl/rse_pkg.sv
package rse_pkg;
  localparam int OP_W   = 64;
  localparam int FRAC_W = 52;            // widest fraction
  localparam int EXPI_W = 11;            // widest exponent
  localparam int EXPS_W = EXPI_W + 1;    // signed working exponent
  localparam int TAB_W  = 7;
  localparam int IDX_W  = 7;
  localparam int LZ_W   = $clog2(FRAC_W);

  typedef enum logic [1:0] {
    FMT_HALF = 2'd0,
    FMT_SNGL = 2'd1,
    FMT_DBL  = 2'd2,
    FMT_RSV  = 2'd3
  } fmt_e;

  // 3*bias - 1 for each format
  function automatic logic [EXPS_W-1:0] bias3m1(fmt_e f);
    case (f)
      FMT_HALF: return EXPS_W'(3 * 15 - 1);
      FMT_SNGL: return EXPS_W'(3 * 127 - 1);
      default:  return EXPS_W'(3 * 1023 - 1);
    endcase
  endfunction

  // builds a right-aligned value from sign, exponent and top 7 fraction bits
  function automatic logic [OP_W-1:0] pack_fp(fmt_e f, logic s,
                                              logic [EXPI_W-1:0] e,
                                              logic [TAB_W-1:0] t);
    case (f)
      FMT_HALF: return {48'b0, s, e[4:0], t, 3'b0};
      FMT_SNGL: return {32'b0, s, e[7:0], t, 16'b0};
      default:  return {s, e, t, 45'b0};
    endcase
  endfunction

  function automatic logic [OP_W-1:0] quiet_nan(fmt_e f);
    return pack_fp(f, 1'b0, '1, 7'h40);
  endfunction
endpackage

// File: rtl/rse_unpack.sv
module rse_unpack
  import rse_pkg::*;
(
  input  fmt_e              fmt,
  input  logic [OP_W-1:0]   op,
  output logic              sign,
  output logic [EXPI_W-1:0] exp_raw,
  output logic [FRAC_W-1:0] frac_al,   // fraction aligned to bit FRAC_W-1
  output logic              is_zero,
  output logic              is_sub,
  output logic              is_inf,
  output logic              is_nan,
  output logic              is_snan
);
  logic exp_ones;

  always_comb begin
    case (fmt)
      FMT_HALF: begin
        sign     = op[15];
        exp_raw  = {6'b0, op[14:10]};
        frac_al  = {op[9:0], 42'b0};
        exp_ones = &op[14:10];
      end
      FMT_SNGL: begin
        sign     = op[31];
        exp_raw  = {3'b0, op[30:23]};
        frac_al  = {op[22:0], 29'b0};
        exp_ones = &op[30:23];
      end
      default: begin
        sign     = op[63];
        exp_raw  = op[62:52];
        frac_al  = op[51:0];
        exp_ones = &op[62:52];
      end
    endcase
    is_zero = (exp_raw == '0) && (frac_al == '0);
    is_sub  = (exp_raw == '0) && (frac_al != '0);
    is_inf  = exp_ones && (frac_al == '0);
    is_nan  = exp_ones && (frac_al != '0);
    is_snan = is_nan && !frac_al[FRAC_W-1];
  end
endmodule

// File: rtl/rse_norm.sv
module rse_norm
  import rse_pkg::*;
(
  input  logic                 is_sub,
  input  logic [EXPI_W-1:0]    exp_raw,
  input  logic [FRAC_W-1:0]    frac_al,
  output logic [EXPS_W-1:0]    exp_n,    // two's complement working exponent
  output logic [IDX_W-2:0]     frac_top  // six leading fraction bits after normalising
);
  logic [LZ_W-1:0]   lz;
  logic              found;
  logic [FRAC_W-1:0] shifted;

  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = FRAC_W - 1; i >= 0; i--) begin
      if (!found && frac_al[i]) begin
        lz    = LZ_W'(FRAC_W - 1 - i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    if (is_sub) begin
      shifted = frac_al << (lz + 1'b1);
      exp_n   = EXPS_W'(0) - EXPS_W'(lz);
    end else begin
      shifted = frac_al;
      exp_n   = {1'b0, exp_raw};
    end
    frac_top = shifted[FRAC_W-1 -: IDX_W-1];
  end
endmodule

// File: rtl/rse_rom.sv
module rse_rom
  import rse_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output logic [TAB_W-1:0] val
);
  // even-parity half: operands in [2,4) of a binade pair
  localparam logic [TAB_W-1:0] EVEN_T [64] = '{
    52, 51, 50, 48, 47, 46, 44, 43, 42, 41, 40, 39, 38, 36, 35, 34,
    33, 32, 31, 30, 30, 29, 28, 27, 26, 25, 24, 23, 23, 22, 21, 20,
    19, 19, 18, 17, 16, 16, 15, 14, 14, 13, 12, 12, 11, 10, 10,  9,
     9,  8,  7,  7,  6,  6,  5,  4,  4,  3,  3,  2,  2,  1,  1,  0};
  // odd-parity half: operands in [1,2)
  localparam logic [TAB_W-1:0] ODD_T [64] = '{
    127, 125, 123, 121, 119, 118, 116, 114, 113, 111, 109, 108, 106, 105, 103, 102,
    100,  99,  97,  96,  95,  93,  92,  91,  90,  88,  87,  86,  85,  84,  83,  82,
     80,  79,  78,  77,  76,  75,  74,  73,  72,  71,  70,  70,  69,  68,  67,  66,
     65,  64,  63,  63,  62,  61,  60,  59,  59,  58,  57,  56,  56,  55,  54,  53};

  always_comb val = idx[IDX_W-1] ? ODD_T[idx[IDX_W-2:0]] : EVEN_T[idx[IDX_W-2:0]];
endmodule

// File: rtl/rsqrt_est.sv
module rsqrt_est
  import rse_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [1:0]      in_fmt,
  input  logic [OP_W-1:0] in_op,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [OP_W-1:0] out_data,
  output logic            out_invalid,
  output logic            out_divzero
);
  fmt_e               fmt;
  logic               sign, is_zero, is_sub, is_inf, is_nan, is_snan;
  logic [EXPI_W-1:0]  exp_raw;
  logic [FRAC_W-1:0]  frac_al;
  logic [EXPS_W-1:0]  exp_n;
  logic [IDX_W-2:0]   frac_top;
  logic [TAB_W-1:0]   tab_val;
  logic [EXPS_W-1:0]  exp_num;
  logic [EXPI_W-1:0]  exp_out;
  logic [OP_W-1:0]    res_d;
  logic               inv_d, dz_d;
  logic               accept;

  assign fmt = fmt_e'(in_fmt);

  rse_unpack u_unpack (
    .fmt(fmt), .op(in_op), .sign(sign), .exp_raw(exp_raw), .frac_al(frac_al),
    .is_zero(is_zero), .is_sub(is_sub), .is_inf(is_inf), .is_nan(is_nan),
    .is_snan(is_snan)
  );

  rse_norm u_norm (
    .is_sub(is_sub), .exp_raw(exp_raw), .frac_al(frac_al),
    .exp_n(exp_n), .frac_top(frac_top)
  );

  rse_rom u_rom (
    .idx({exp_n[0], frac_top}),
    .val(tab_val)
  );

  // result exponent: floor((3*bias - 1 - e) / 2), numerator always positive
  assign exp_num = bias3m1(fmt) - exp_n;
  assign exp_out = EXPI_W'(exp_num >> 1);

  always_comb begin
    inv_d = 1'b0;
    dz_d  = 1'b0;
    if (fmt == FMT_RSV) begin
      res_d = quiet_nan(FMT_DBL);
      inv_d = 1'b1;
    end else if (is_nan) begin
      res_d = quiet_nan(fmt);
      inv_d = is_snan;
    end else if (is_zero) begin
      res_d = pack_fp(fmt, sign, '1, '0);
      dz_d  = 1'b1;
    end else if (sign) begin
      res_d = quiet_nan(fmt);
      inv_d = 1'b1;
    end else if (is_inf) begin
      res_d = '0;
    end else begin
      res_d = pack_fp(fmt, 1'b0, exp_out, tab_val);
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_invalid <= 1'b0;
      out_divzero <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_data    <= res_d;
      out_invalid <= inv_d;
      out_divzero <= dz_d;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R8
  accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
  // R4
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_invalid && out_divzero));
  // R7
  sub_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_sub |-> (exp_n[EXPS_W-1] || exp_n == '0));
  // R3
  class_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({is_zero, is_sub, is_inf, is_nan}));
endmodule

// File: tb/test_rsqrt_est.sv
`timescale 1ns/1ps
module test_rsqrt_est;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b1;
  logic [1:0]  in_fmt = 2'd0;
  logic [63:0] in_op = '0;
  logic        in_ready, out_valid, out_invalid, out_divzero;
  logic [63:0] out_data;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  rsqrt_est i_rsqrt_est (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fmt(in_fmt), .in_op(in_op), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_invalid(out_invalid), .out_divzero(out_divzero)
  );

  int t_even [64] = '{
    52, 51, 50, 48, 47, 46, 44, 43, 42, 41, 40, 39, 38, 36, 35, 34,
    33, 32, 31, 30, 30, 29, 28, 27, 26, 25, 24, 23, 23, 22, 21, 20,
    19, 19, 18, 17, 16, 16, 15, 14, 14, 13, 12, 12, 11, 10, 10,  9,
     9,  8,  7,  7,  6,  6,  5,  4,  4,  3,  3,  2,  2,  1,  1,  0};
  int t_odd [64] = '{
    127, 125, 123, 121, 119, 118, 116, 114, 113, 111, 109, 108, 106, 105, 103, 102,
    100,  99,  97,  96,  95,  93,  92,  91,  90,  88,  87,  86,  85,  84,  83,  82,
     80,  79,  78,  77,  76,  75,  74,  73,  72,  71,  70,  70,  69,  68,  67,  66,
     65,  64,  63,  63,  62,  61,  60,  59,  59,  58,  57,  56,  56,  55,  54,  53};

  function automatic int ew(int f); return f == 0 ? 5 : f == 1 ? 8 : 11; endfunction
  function automatic int fw(int f); return f == 0 ? 10 : f == 1 ? 23 : 52; endfunction

  function automatic void ref_model(input int fmt, input logic [63:0] op,
      output logic [63:0] res, output logic inv, output logic dz, output string tag);
    int E, F, e, idx, tv;
    longint bias, oe;
    logic [63:0] fm, em, ex, fr, f, qn;
    logic sg;
    inv = 0; dz = 0; res = '0;
    if (fmt == 3) begin
      res = 64'h7FF8_0000_0000_0000; inv = 1; tag = "R1"; return;
    end
    E = ew(fmt); F = fw(fmt);
    fm = (64'd1 << F) - 1; em = (64'd1 << E) - 1;
    sg = op[E+F]; ex = (op >> F) & em; fr = op & fm;
    qn = (em << F) | (64'd1 << (F - 1));
    bias = (longint'(1) << (E - 1)) - 1;
    if (ex == em && fr != 0) begin
      res = qn; inv = !fr[F-1]; tag = "R3";
    end else if (ex == 0 && fr == 0) begin
      res = (64'(sg) << (E + F)) | (em << F); dz = 1; tag = "R4";
    end else if (sg) begin
      res = qn; inv = 1; tag = "R2";
    end else if (ex == em) begin
      res = 0; tag = "R5";
    end else begin
      e = int'(ex); f = fr;
      tag = (ex == 0) ? "R7" : "R6";
      if (ex == 0) begin
        while (((f >> (F - 1)) & 1) == 0) begin f = f << 1; e = e - 1; end
        f = (f << 1) & fm;
      end
      idx = ((e & 1) << 6) | int'(f >> (F - 6));
      tv = (idx < 64) ? t_even[idx] : t_odd[idx - 64];
      oe = (3 * bias - 1 - longint'(e)) / 2;
      res = (64'(oe) << F) | (64'(tv) << (F - 7));
    end
  endfunction

  task automatic check(input bit ok, input string tag, input logic [67:0] act, input logic [67:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_one(input int fmt, input logic [63:0] op);
    logic [63:0] r; logic iv, dz; string tg;
    ref_model(fmt, op, r, iv, dz, tg);
    @(negedge clk);
    in_valid = 1; in_fmt = 2'(fmt); in_op = op; out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check(out_valid && out_data == r && out_invalid == iv && out_divzero == dz, tg,
          {out_valid, out_invalid, out_divzero, 1'b0, out_data}, {1'b1, iv, dz, 1'b0, r});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] ra, rb; logic i1, d1; string tg;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!out_valid && in_ready, "R9", {66'b0, out_valid, in_ready}, {66'b0, 2'b01});
    rst_n = 1;
    @(negedge clk);
    check(!out_valid && in_ready, "R9", {66'b0, out_valid, in_ready}, {66'b0, 2'b01});

    // directed corners
    run_one(0, 64'h3C00);                 // R6 1.0 half, index 64
    run_one(0, 64'h3FFF);                 // R6 odd exponent, last index
    run_one(0, 64'h4000);                 // R6 2.0 half, index 0
    run_one(0, 64'h43FF);                 // R6 even exponent, index 63
    run_one(1, 64'h3F80_0000);            // R6 single 1.0
    run_one(2, 64'h3FF0_0000_0000_0000);  // R6 double 1.0
    run_one(0, 64'h0001);                 // R7 smallest half subnormal
    run_one(1, 64'h0040_0000);            // R7 top-bit subnormal
    run_one(2, 64'h0000_0000_0000_0001);  // R7 smallest double subnormal
    run_one(0, 64'h0000);                 // R4 +0
    run_one(1, 64'h8000_0000);            // R4 -0
    run_one(2, 64'h7FF0_0000_0000_0000);  // R5 +inf
    run_one(0, 64'hFC00);                 // R2 -inf
    run_one(1, 64'hBF80_0000);            // R2 negative normal
    run_one(2, 64'h8000_0000_0000_0001);  // R2 negative subnormal
    run_one(1, 64'h7F80_0001);            // R3 signalling
    run_one(0, 64'hFE01);                 // R3 quiet, negative sign
    run_one(3, 64'h3FF0_0000_0000_0000);  // R1 reserved code
    run_one(0, 64'hDEAD_BEEF_CAFE_3C00);  // R1 upper bits ignored

    // random mix and forced subnormals per format
    for (int k = 0; k < 900; k++) begin
      int fm = k % 3;
      logic [63:0] op = {$urandom, $urandom};
      if ((k / 3) % 3 == 1) begin
        int F = fw(fm), len = 1 + ($urandom % F);
        op = op & ((64'd1 << len) - 1);    // positive subnormal, random length (R7)
      end else if ((k / 3) % 3 == 2) begin
        op[ew(fm)+fw(fm)] = 1'b0;          // positive operand (R6)
      end
      run_one(fm, op);
    end

    // R8 stall with a second operand waiting
    ref_model(1, 64'h4080_0000, ra, i1, d1, tg);
    ref_model(0, 64'h0000, rb, i1, d1, tg);
    @(negedge clk);
    in_valid = 1; in_fmt = 2'd1; in_op = 64'h4080_0000; out_ready = 0;
    @(negedge clk);
    check(out_valid && !in_ready && out_data == ra, "R8",
          {2'b0, out_valid, in_ready, out_data}, {2'b0, 2'b10, ra});
    in_fmt = 2'd0; in_op = 64'h0000;
    @(negedge clk);
    check(out_valid && out_data == ra, "R8", {3'b0, out_valid, out_data}, {3'b0, 1'b1, ra});
    out_ready = 1;
    @(negedge clk);
    check(out_valid && out_data == rb && out_divzero, "R8",
          {3'b0, out_valid, out_data}, {3'b0, 1'b1, rb});
    in_valid = 0;
    @(negedge clk);
    check(!out_valid && in_ready, "R8", {66'b0, out_valid, in_ready}, {66'b0, 2'b01});

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule